// File: doc/BRIEF.md
# Micro-op Wakeup and Dispatch Scheduler

This block holds renamed micro-ops between rename and execution. Each cycle it accepts up to four new micro-ops. Each one carries an operation class, two source tags with a ready flag each, and a destination tag. The block keeps each micro-op until both of its sources are known to be available. Finished producers announce their destination tags on a result broadcast bus. Every waiting source whose tag matches is marked available, and that includes sources arriving on the insert lanes in the same cycle.

Each cycle, every execution port takes at most one eligible micro-op from the classes it is built to run. Among the candidates a port takes the oldest one, and each entry is dispatched at most once. Selection looks only at readiness and age, never at position in the buffer. A micro-op that waits on a slow load therefore never holds back younger work that is ready. Operand values, the execution units and retirement are handled elsewhere. Only tags and classes pass through here.

Top module: `uop_sched`

## Requirements
- R1: After reset, no port shows a valid micro-op and `ins_ready` is high.
- R2: The station holds `DEPTH` (default 36) entries. `ins_ready` is high exactly when at least `LANES` entries are free. While `ins_ready` is low, asserted insert lanes are ignored and nothing from them is ever dispatched.
- R3: An entry is eligible only when both of its source ready flags are set. Until then it does not dispatch, however long it waits.
- R4: A broadcast tag marks every matching source ready in the same cycle. This covers waiting entries and sources on the insert lanes in that cycle. An entry whose last source is woken this way can dispatch in the next cycle.
- R5: An entry inserted with both sources ready appears on a port in the first cycle after the insert edge.
- R6: Class codes map to ports as follows:
  - 0 integer ALU: ports 0, 1, 5
  - 1 multiply: port 0
  - 2 branch: port 5
  - 3 vector: ports 1, 5
  - 4 load address: port 2
  - 5 store address: port 3
  - 6 store data: port 4
  - 7: no port
- R7: Each port takes the oldest eligible entry of a class it accepts. Ports are served in the order 0, 1, 2, 3, 4, 5, and each skips entries already taken by a lower-numbered port. Age follows insert cycle, and within one cycle a lower lane number is older.
- R8: A ready younger entry dispatches ahead of an older entry that still waits.
- R9: Several ports can dispatch in one cycle. No entry goes to two ports, and a dispatched entry is freed at that clock edge.
- R10: A port whose `disp_ready` is low shows `disp_valid` low and takes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | LANES | Insert lane valid |
| ins_cls | input | LANES*3 | Class code per lane |
| ins_src1 | input | LANES*TAGW | First source tag per lane |
| ins_src1_rdy | input | LANES | First source already available |
| ins_src2 | input | LANES*TAGW | Second source tag per lane |
| ins_src2_rdy | input | LANES | Second source already available |
| ins_dst | input | LANES*TAGW | Destination tag per lane |
| ins_ready | output | 1 | All insert lanes can be accepted this cycle |
| wb_valid | input | NWB | Broadcast lane valid |
| wb_tag | input | NWB*TAGW | Broadcast result tag |
| disp_valid | output | 6 | Port carries a micro-op |
| disp_ready | input | 6 | Port can accept this cycle |
| disp_cls | output | 18 | Class code per port |
| disp_dst | output | 6*TAGW | Destination tag per port |

## Verification
Corrupt age state shows up as a wrong dispatch order on one port. This becomes visible once two eligible entries of one class compete, which is normally in the first such cycle. A lost or spurious ready flag shows up as an entry that never leaves, or as one that leaves the cycle after insert while a source is still pending. A free-list error shows up as `ins_ready` at the wrong moment, or as a tag appearing twice or not at all. The scoreboard catches these as soon as the next dispatch of that tag is expected, or, for a missing tag, at the final drain.

// File: rtl/uop_sched_pkg.sv
package uop_sched_pkg;
  localparam int N_PORTS = 6;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 3'd0,
    CLS_MUL  = 3'd1,
    CLS_BR   = 3'd2,
    CLS_VEC  = 3'd3,
    CLS_LD   = 3'd4,
    CLS_STA  = 3'd5,
    CLS_STD  = 3'd6,
    CLS_NONE = 3'd7
  } uop_cls_e;

  // bit p set: port p can execute this class
  function automatic logic [N_PORTS-1:0] port_mask(input logic [CLS_W-1:0] cls);
    logic [N_PORTS-1:0] m;
    case (cls)
      CLS_ALU: m = 6'b100011;
      CLS_MUL: m = 6'b000001;
      CLS_BR:  m = 6'b100000;
      CLS_VEC: m = 6'b100010;
      CLS_LD:  m = 6'b000100;
      CLS_STA: m = 6'b001000;
      CLS_STD: m = 6'b010000;
      default: m = 6'b000000;
    endcase
    return m;
  endfunction

  function automatic logic port_ok(input logic [CLS_W-1:0] cls, input int p);
    logic [N_PORTS-1:0] m;
    m = port_mask(cls);
    return m[p[2:0]];
  endfunction
endpackage

// File: rtl/uop_slot_alloc.sv
module uop_slot_alloc #(
  parameter int DEPTH = 36,
  parameter int LANES = 4
) (
  input  logic [DEPTH-1:0] free_vec,
  output logic [DEPTH-1:0] slot_oh [LANES],
  output logic             room
);
  // lane l takes the l-th lowest free slot
  always_comb begin
    logic [DEPTH-1:0] rem;
    rem = free_vec;
    for (int l = 0; l < LANES; l++) begin
      slot_oh[l] = rem & (~rem + DEPTH'(1));
      rem        = rem & ~slot_oh[l];
    end
  end

  assign room = ($countones(free_vec) >= LANES);
endmodule

// File: rtl/uop_tag_match.sv
module uop_tag_match #(
  parameter int TAGW = 7,
  parameter int NWB  = 2
) (
  input  logic [TAGW-1:0]     tag,
  input  logic [NWB-1:0]      wb_valid,
  input  logic [NWB*TAGW-1:0] wb_tag,
  output logic                hit
);
  always_comb begin
    hit = 1'b0;
    for (int b = 0; b < NWB; b++)
      if (wb_valid[b] && (wb_tag[b*TAGW +: TAGW] == tag)) hit = 1'b1;
  end
endmodule

// File: rtl/uop_pick_oldest.sv
module uop_pick_oldest #(
  parameter int DEPTH = 36
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [DEPTH-1:0] older [DEPTH],
  output logic [DEPTH-1:0] grant
);
  // older[i][j] set: entry j was inserted before entry i
  always_comb
    for (int i = 0; i < DEPTH; i++)
      grant[i] = cand[i] & ~(|(cand & older[i]));
endmodule

// File: rtl/uop_sched.sv
module uop_sched
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 36,
  parameter int LANES = 4,
  parameter int TAGW  = 7,
  parameter int NWB   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           ins_valid,
  input  logic [LANES*CLS_W-1:0]     ins_cls,
  input  logic [LANES*TAGW-1:0]      ins_src1,
  input  logic [LANES-1:0]           ins_src1_rdy,
  input  logic [LANES*TAGW-1:0]      ins_src2,
  input  logic [LANES-1:0]           ins_src2_rdy,
  input  logic [LANES*TAGW-1:0]      ins_dst,
  output logic                       ins_ready,
  input  logic [NWB-1:0]             wb_valid,
  input  logic [NWB*TAGW-1:0]        wb_tag,
  output logic [N_PORTS-1:0]         disp_valid,
  input  logic [N_PORTS-1:0]         disp_ready,
  output logic [N_PORTS*CLS_W-1:0]   disp_cls,
  output logic [N_PORTS*TAGW-1:0]    disp_dst
);
  localparam int NP = N_PORTS;
  localparam int CW = CLS_W;

  // entry state
  logic [DEPTH-1:0] valid_q, s1_rdy_q, s2_rdy_q;
  logic [CW-1:0]    cls_q    [DEPTH];
  logic [TAGW-1:0]  s1_tag_q [DEPTH];
  logic [TAGW-1:0]  s2_tag_q [DEPTH];
  logic [TAGW-1:0]  dst_q    [DEPTH];
  logic [DEPTH-1:0] older_q  [DEPTH];

  // named internal events
  logic [DEPTH-1:0] elig, grant_all, wake1, wake2;
  logic [LANES-1:0] acc, lane_w1, lane_w2;
  logic [DEPTH-1:0] slot_oh  [LANES];
  logic [DEPTH-1:0] prior_oh [LANES];
  logic             room;

  uop_slot_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
    .free_vec(~valid_q), .slot_oh(slot_oh), .room(room)
  );

  assign ins_ready = room;
  assign acc       = ins_valid & {LANES{room}};

  always_comb begin
    prior_oh[0] = '0;
    for (int l = 1; l < LANES; l++) prior_oh[l] = prior_oh[l-1] | slot_oh[l-1];
  end

  // wakeup on stored and incoming sources
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    uop_tag_match #(.TAGW(TAGW), .NWB(NWB)) u_w1 (
      .tag(s1_tag_q[i]), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(wake1[i]));
    uop_tag_match #(.TAGW(TAGW), .NWB(NWB)) u_w2 (
      .tag(s2_tag_q[i]), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(wake2[i]));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    uop_tag_match #(.TAGW(TAGW), .NWB(NWB)) u_l1 (
      .tag(ins_src1[l*TAGW +: TAGW]), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(lane_w1[l]));
    uop_tag_match #(.TAGW(TAGW), .NWB(NWB)) u_l2 (
      .tag(ins_src2[l*TAGW +: TAGW]), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(lane_w2[l]));
  end

  assign elig = valid_q & s1_rdy_q & s2_rdy_q;

  // per-port selection chain
  logic [DEPTH-1:0] cls_col [NP];
  logic [DEPTH-1:0] cand    [NP];
  logic [DEPTH-1:0] grant   [NP];
  logic [DEPTH-1:0] taken   [NP+1];

  always_comb
    for (int i = 0; i < DEPTH; i++)
      for (int p = 0; p < NP; p++)
        cls_col[p][i] = port_ok(cls_q[i], p);

  assign taken[0] = '0;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign cand[p] = elig & cls_col[p] & ~taken[p] & {DEPTH{disp_ready[p]}};
    uop_pick_oldest #(.DEPTH(DEPTH)) u_pick (
      .cand(cand[p]), .older(older_q), .grant(grant[p]));
    assign taken[p+1]    = taken[p] | grant[p];
    assign disp_valid[p] = |grant[p];
  end

  assign grant_all = taken[NP];

  always_comb begin
    disp_dst = '0;
    disp_cls = '0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < DEPTH; i++)
        if (grant[p][i]) begin
          disp_dst[p*TAGW +: TAGW] = disp_dst[p*TAGW +: TAGW] | dst_q[i];
          disp_cls[p*CW +: CW]     = disp_cls[p*CW +: CW] | cls_q[i];
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      s1_rdy_q <= '0;
      s2_rdy_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        older_q[i]  <= '0;
        cls_q[i]    <= '0;
        s1_tag_q[i] <= '0;
        s2_tag_q[i] <= '0;
        dst_q[i]    <= '0;
      end
    end else begin
      valid_q  <= valid_q & ~grant_all;
      s1_rdy_q <= s1_rdy_q | wake1;
      s2_rdy_q <= s2_rdy_q | wake2;
      for (int l = 0; l < LANES; l++)
        if (acc[l])
          for (int i = 0; i < DEPTH; i++)
            if (slot_oh[l][i]) begin
              valid_q[i]  <= 1'b1;
              cls_q[i]    <= ins_cls[l*CW +: CW];
              s1_tag_q[i] <= ins_src1[l*TAGW +: TAGW];
              s2_tag_q[i] <= ins_src2[l*TAGW +: TAGW];
              dst_q[i]    <= ins_dst[l*TAGW +: TAGW];
              s1_rdy_q[i] <= ins_src1_rdy[l] | lane_w1[l];
              s2_rdy_q[i] <= ins_src2_rdy[l] | lane_w2[l];
              for (int j = 0; j < DEPTH; j++) older_q[j][i] <= 1'b0;
              older_q[i] <= valid_q | prior_oh[l];
            end
    end
  end
endmodule

// File: rtl/uop_sched_chk.sv
module uop_sched_chk
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 36,
  parameter int LANES = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ins_ready,
  input logic [N_PORTS-1:0]         disp_valid,
  input logic [N_PORTS-1:0]         disp_ready,
  input logic [N_PORTS*CLS_W-1:0]   disp_cls,
  input logic [DEPTH-1:0]           valid_q,
  input logic [DEPTH-1:0]           elig,
  input logic [DEPTH-1:0]           grant_all,
  input logic [LANES-1:0]           acc
);
  // R10
  port_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid & ~disp_ready) == '0);

  // R9
  grant_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_all) == $countones(disp_valid));

  // R3
  elig_only_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_all & ~elig) == '0);

  // R2
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(valid_q) ==
              $past($countones(valid_q)) + $past($countones(acc)) - $past($countones(grant_all))));

  // R2
  full_chk: assert property (@(posedge clk) disable iff (rst)
    !ins_ready |-> ($countones(valid_q) > DEPTH - LANES));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_cls
    // R6
    class_port_chk: assert property (@(posedge clk) disable iff (rst)
      disp_valid[p] |-> port_ok(disp_cls[p*CLS_W +: CLS_W], p));
  end
endmodule

bind uop_sched uop_sched_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ins_ready(ins_ready), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_cls(disp_cls), .valid_q(valid_q),
  .elig(elig), .grant_all(grant_all), .acc(acc)
);

// File: tb/uop_sched_test.sv
`timescale 1ns/1ps
module uop_sched_test;
  localparam int DEPTH = 36, LANES = 4, TW = 7, NWB = 2, NP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0]    ins_valid = '0;
  logic [LANES*3-1:0]  ins_cls = '0;
  logic [LANES*TW-1:0] ins_src1 = '0, ins_src2 = '0, ins_dst = '0;
  logic [LANES-1:0]    ins_src1_rdy = '0, ins_src2_rdy = '0;
  logic                ins_ready;
  logic [NWB-1:0]      wb_valid = '0;
  logic [NWB*TW-1:0]   wb_tag = '0;
  logic [NP-1:0]       disp_valid;
  logic [NP-1:0]       disp_ready = '1;
  logic [NP*3-1:0]     disp_cls;
  logic [NP*TW-1:0]    disp_dst;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  uop_sched #(.DEPTH(DEPTH), .LANES(LANES), .TAGW(TW), .NWB(NWB)) uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_cls(ins_cls),
    .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy), .ins_src2(ins_src2),
    .ins_src2_rdy(ins_src2_rdy), .ins_dst(ins_dst), .ins_ready(ins_ready),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_cls(disp_cls), .disp_dst(disp_dst));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ins_valid = '0; wb_valid = '0;
  endtask

  task automatic put(input int l, input int c, input int s1, input bit r1,
                     input int s2, input bit r2, input int d);
    ins_valid[l] = 1'b1;
    ins_cls[l*3 +: 3] = 3'(c);
    ins_src1[l*TW +: TW] = TW'(s1);  ins_src1_rdy[l] = r1;
    ins_src2[l*TW +: TW] = TW'(s2);  ins_src2_rdy[l] = r2;
    ins_dst[l*TW +: TW] = TW'(d);
  endtask

  task automatic bcast(input int b, input int t);
    wb_valid[b] = 1'b1;
    wb_tag[b*TW +: TW] = TW'(t);
  endtask

  // driver side of the scoreboard: expected (port, tag) in per-port order
  task automatic expect_on(input int p, input int d);
    exp_q.push_back(p*256 + d);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pdst(input int p);
    return int'(disp_dst[p*TW +: TW]);
  endfunction

  // monitor side: each handshake must match the first pending item of its port (R6, R7, R9)
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < NP; p++) begin
        if (disp_valid[p] && disp_ready[p]) begin
          int idx;
          idx = -1;
          for (int k = 0; k < exp_q.size(); k++)
            if (idx < 0 && exp_q[k] / 256 == p) idx = k;
          checks++;
          if (idx < 0) begin
            errors++;
            $display("FAIL R2/R9 port %0d: actual tag %0d expected no dispatch", p, pdst(p));
          end else begin
            if (exp_q[idx] % 256 != pdst(p)) begin
              errors++;
              $display("FAIL R6/R7 port %0d order: actual %0d expected %0d", p, pdst(p), exp_q[idx] % 256);
            end
            exp_q.delete(idx);
          end
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int m;
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    check(disp_valid == '0, "R1", "disp_valid after reset", int'(disp_valid), 0);
    check(ins_ready == 1'b1, "R1", "ins_ready after reset", int'(ins_ready), 1);

    // R5 ready-at-insert dispatch timing
    put(0, 0, 0, 1, 0, 1, 1); expect_on(0, 1);
    check(disp_valid == '0, "R5", "valid before insert edge", int'(disp_valid), 0);
    step(); idle();
    check(disp_valid[0] == 1'b1, "R5", "port0 valid cycle after insert", int'(disp_valid[0]), 1);
    step();

    // R6 and R9: every class on its port, several ports per cycle
    put(0, 4, 0, 1, 0, 1, 20); expect_on(2, 20);
    put(1, 5, 0, 1, 0, 1, 21); expect_on(3, 21);
    put(2, 6, 0, 1, 0, 1, 22); expect_on(4, 22);
    put(3, 1, 0, 1, 0, 1, 23); expect_on(0, 23);
    step(); idle();
    put(0, 2, 0, 1, 0, 1, 24); expect_on(5, 24);
    put(1, 3, 0, 1, 0, 1, 25); expect_on(1, 25);
    put(2, 0, 0, 1, 0, 1, 26); expect_on(0, 26);
    check(disp_valid == 6'b011101, "R9", "ports 0,2,3,4 together", int'(disp_valid), 'b011101);
    step(); idle();
    check(disp_valid == 6'b100011, "R6", "branch/vector/alu ports", int'(disp_valid), 'b100011);
    step();

    // R7 lane order decides age inside one cycle
    put(0, 0, 0, 1, 0, 1, 30); expect_on(0, 30);
    put(1, 0, 0, 1, 0, 1, 31); expect_on(1, 31);
    put(2, 0, 0, 1, 0, 1, 32); expect_on(5, 32);
    put(3, 0, 0, 1, 0, 1, 33); expect_on(0, 33);
    step(); idle();
    check(disp_valid == 6'b100011, "R7", "three alu ports busy", int'(disp_valid), 'b100011);
    step();
    check(disp_valid == 6'b000001, "R7", "youngest alu next cycle", int'(disp_valid), 1);
    step();

    // R8 younger ready op bypasses an older one waiting on a load
    put(0, 0, 90, 0, 0, 1, 40);
    step(); idle();
    put(0, 0, 0, 1, 0, 1, 41); expect_on(0, 41);
    step(); idle();
    check(disp_valid[0] && pdst(0) == 41, "R8", "younger op on port0", pdst(0), 41);
    repeat (8) step();
    check(disp_valid == '0, "R3", "waiting op stays held", int'(disp_valid), 0);
    bcast(1, 90); expect_on(0, 40);
    step(); idle();
    check(disp_valid[0] && pdst(0) == 40, "R4", "woken op next cycle", pdst(0), 40);
    step();

    // R3 both sources required
    put(0, 0, 51, 0, 52, 0, 50);
    step(); idle();
    bcast(0, 51);
    step(); idle();
    check(disp_valid == '0, "R3", "one source woken only", int'(disp_valid), 0);
    bcast(0, 52); expect_on(0, 50);
    step(); idle();
    check(disp_valid[0] && pdst(0) == 50, "R3", "second source woken", pdst(0), 50);
    step();

    // R4 broadcast in the insert cycle
    put(0, 0, 56, 0, 0, 1, 55); bcast(0, 56); expect_on(0, 55);
    step(); idle();
    check(disp_valid[0] && pdst(0) == 55, "R4", "same-cycle wakeup", pdst(0), 55);
    step();

    // R7 age across cycles, R10 gated ports
    disp_ready = 6'b000001;
    put(0, 0, 70, 0, 0, 1, 60);
    step(); idle();
    put(0, 0, 71, 0, 0, 1, 61);
    step(); idle();
    bcast(0, 71); bcast(1, 70);
    expect_on(0, 60); expect_on(0, 61);
    step(); idle();
    check(disp_valid[0] && pdst(0) == 60, "R7", "older entry first", pdst(0), 60);
    check(disp_valid[1] == 1'b0, "R10", "port1 not ready stays idle", int'(disp_valid[1]), 0);
    step();
    check(disp_valid[0] && pdst(0) == 61, "R7", "younger entry second", pdst(0), 61);
    step();

    // R2 fill to capacity with ports closed
    disp_ready = '0;
    for (int n = 0; n < DEPTH / LANES; n++) begin
      for (int k = 0; k < LANES; k++) begin
        m = n*LANES + k;
        put(k, 0, 0, 1, 0, 1, 64 + m);
        expect_on((m % 3 == 0) ? 0 : ((m % 3 == 1) ? 1 : 5), 64 + m);
      end
      step(); idle();
    end
    check(ins_ready == 1'b0, "R2", "ins_ready when full", int'(ins_ready), 0);
    check(disp_valid == '0, "R10", "no valid with ports closed", int'(disp_valid), 0);
    put(0, 0, 0, 1, 0, 1, 120);
    step(); idle();
    step();
    disp_ready = '1;
    repeat (14) step();
    check(ins_ready == 1'b1, "R2", "ins_ready after drain", int'(ins_ready), 1);
    check(disp_valid == '0, "R2", "ignored insert never dispatched", int'(disp_valid), 0);
    check(exp_q.size() == 0, "R9", "every entry dispatched once", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule